// File: doc/BRIEF.md
# Power-Fail Time-Save Controller

This block watches a digital "main supply good" indication and reacts when main power goes away. A failure only counts once the indication has stayed low for a fixed run of clock cycles, so short dips on the supply are ignored. When a failure is accepted, the block does four things on one clock edge. It raises a power-fail interrupt. It locks the processor bus so that writes no longer get through. It moves the supply select over to the battery. It takes a single parallel snapshot of the live time counters and puts it in a time-save bank.

Recovery uses the same filter in the other direction. Main power must read good for the same run of cycles before the lockout is released and the supply select goes back to main. The snapshot is kept until the next failure writes over it. A small sticky status word records four things: the power-fail interrupt, the first application of battery, the return of system power, and a low-battery report. Software clears a status bit by writing a 1 to its position, but only while the bus is not locked.

Top module: `pwr_fail_ctl`

## Requirements
- R1: A failure is accepted only after `main_ok` has been sampled low on FILT_CYC consecutive rising edges; a shorter dip changes no output.
- R2: On the edge that accepts a failure, status bit 0 (power-fail) is set and `pf_irq`, which mirrors it, goes high.
- R3: While `bus_lock` is high, `bus_wr_out` is held low whatever `bus_wr_in` does, and status clear writes are ignored.
- R4: On the edge that accepts a failure, `save_time` takes the value of `time_now` sampled at that edge. At all other times it holds, including for the rest of a long failure.
- R5: `on_batt` and `bus_lock` go high on the accepting edge and stay high for as long as the failure is in force.
- R6: After a failure, `main_ok` must be sampled high on FILT_CYC consecutive edges. On that edge `bus_lock` and `on_batt` drop and status bit 2 (system power restored) is set.
- R7: Status bit 1 (battery first applied) is set on the edge after `batt_present` is first seen high. This includes the case where the battery is already present when reset is released.
- R8: Status bit 3 (low battery) is set on any edge where `batt_low` is high, and it stays set after `batt_low` falls.
- R9: A pulse on `clr_wr` clears each status bit whose `clr_mask` bit is 1. If a set condition arrives in the same cycle, the set wins.
- R10: After a synchronous active-low reset, `status` is 0, `pf_irq`, `bus_lock` and `on_batt` are low, and `save_time` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_ok | input | 1 | Raw main-supply-good indication (1 = main above battery) |
| batt_present | input | 1 | Battery detected |
| batt_low | input | 1 | Low-battery comparator result |
| time_now | input | TIME_W | Live time counter value |
| bus_wr_in | input | 1 | Processor write strobe |
| clr_wr | input | 1 | Status clear write strobe |
| clr_mask | input | 4 | Write-1-to-clear mask for the status bits |
| bus_wr_out | output | 1 | Write strobe after the lockout gate |
| pf_irq | output | 1 | Power-fail interrupt |
| bus_lock | output | 1 | Bus lockout active |
| on_batt | output | 1 | Supply select: 1 = battery |
| save_time | output | TIME_W | Time-save bank contents |
| status | output | 4 | Sticky status: bit0 fail, bit1 battery first applied, bit2 system power, bit3 low battery |

## Verification
The bench builds the block with FILT_CYC = 4 and TIME_W = 16. This makes it cheap to sweep every dip length from 1 to 7 cycles, so lengths on both sides of the acceptance threshold are covered. For each dip length that causes a failure, the bench checks that the snapshot equals the counter value on the exact accepting cycle. It checks the recovery filter one cycle short of its threshold and again at the threshold. It also exercises clears that are blocked by the lockout and clears that race against a set.

// File: rtl/pf_pkg.sv
// Shared definitions for the power-fail time-save controller.
// Assumes a 4-bit status word with fixed bit meanings.
package pf_pkg;
    localparam int ST_W         = 4;
    localparam int ST_FAIL      = 0;
    localparam int ST_BATT_INIT = 1;
    localparam int ST_SYS_PWR   = 2;
    localparam int ST_LOW_BATT  = 3;
    typedef logic [ST_W-1:0] status_t;
endpackage

// File: rtl/pf_glitch_filter.sv
// Debounces the raw main-supply-good signal. The filtered state only flips
// once the raw level has disagreed with it for FILT_CYC consecutive edges.
// Assumes FILT_CYC >= 1 and a raw input that is already synchronised.
module pf_glitch_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_ok,
    output logic good,
    output logic fall_evt,
    output logic rise_evt
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_q;
    logic          good_q;
    logic          flip;

    // Flip when the disagreement has lasted the full window.
    always_comb begin
        flip     = (raw_ok != good_q) && (run_q == LAST);
        fall_evt = flip && good_q;
        rise_evt = flip && !good_q;
    end

    // Count the current disagreement run and update the filtered state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            good_q <= 1'b1;
        end else if (raw_ok == good_q) begin
            run_q <= '0;
        end else if (flip) begin
            run_q  <= '0;
            good_q <= raw_ok;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign good = good_q;

    // R1: the filtered state can only change after the raw level disagreed with it.
    p_flip_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(good_q) |-> ($past(raw_ok) != $past(good_q)));
endmodule

// File: rtl/pf_time_latch.sv
// Time-save bank: takes a one-cycle parallel copy of the counters when
// capture is pulsed and holds it otherwise. Assumes capture is a pulse.
module pf_time_latch #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [TIME_W-1:0] time_in,
    output logic [TIME_W-1:0] saved
);
    // Load the snapshot on capture, otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)       saved <= '0;
        else if (capture) saved <= time_in;
    end

    // R4: the bank never changes without a capture.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(saved));
endmodule

// File: rtl/pf_status_regs.sv
// Sticky status bits with write-1-to-clear. A set in the same cycle as a
// clear wins. Assumes clr_en has already been gated by the bus lockout.
module pf_status_regs
    import pf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  status_t set_vec,
    input  logic    clr_en,
    input  status_t clr_mask,
    output status_t q
);
    status_t clr_eff;

    // Only apply the mask when a clear write is actually accepted.
    always_comb clr_eff = clr_en ? clr_mask : '0;

    // Update the sticky bits, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_eff) | set_vec;
    end

    // R9: a set bit stays set unless its clear is accepted.
    for (genvar i = 0; i < ST_W; i++) begin : g_chk
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr_eff[i]) |=> q[i]);
    end
endmodule

// File: rtl/pwr_fail_ctl.sv
// Power-fail controller top. Filters main_ok, and on an accepted failure
// raises the interrupt, locks the bus, selects the battery and snapshots
// the time. Assumes all inputs are synchronous to clk.
module pwr_fail_ctl
    import pf_pkg::*;
#(
    parameter int TIME_W   = 32,
    parameter int FILT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_ok,
    input  logic              batt_present,
    input  logic              batt_low,
    input  logic [TIME_W-1:0] time_now,
    input  logic              bus_wr_in,
    input  logic              clr_wr,
    input  logic [ST_W-1:0]   clr_mask,
    output logic              bus_wr_out,
    output logic              pf_irq,
    output logic              bus_lock,
    output logic              on_batt,
    output logic [TIME_W-1:0] save_time,
    output logic [ST_W-1:0]   status
);
    logic    good, fall_evt, rise_evt;
    logic    batt_q;
    status_t set_vec;

    pf_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_ok(main_ok),
        .good(good), .fall_evt(fall_evt), .rise_evt(rise_evt)
    );

    pf_time_latch #(.TIME_W(TIME_W)) u_save (
        .clk(clk), .rst_n(rst_n), .capture(fall_evt),
        .time_in(time_now), .saved(save_time)
    );

    // Remember the previous battery level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) batt_q <= 1'b0;
        else        batt_q <= batt_present;
    end

    // Collect the set conditions for each status bit.
    always_comb begin
        set_vec               = '0;
        set_vec[ST_FAIL]      = fall_evt;
        set_vec[ST_BATT_INIT] = batt_present && !batt_q;
        set_vec[ST_SYS_PWR]   = rise_evt;
        set_vec[ST_LOW_BATT]  = batt_low;
    end

    pf_status_regs u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .clr_en(clr_wr && !bus_lock), .clr_mask(clr_mask), .q(status)
    );

    // Drive the lockout, supply select, interrupt and gated write.
    always_comb begin
        bus_lock   = !good;
        on_batt    = !good;
        pf_irq     = status[ST_FAIL];
        bus_wr_out = bus_wr_in && !bus_lock;
    end

    // R4: when the lockout begins, the snapshot holds the time from that edge.
    p_save_on_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> (save_time == $past(time_now)));
    // R2: the interrupt is up whenever the lockout has just begun.
    p_irq_on_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_lock) |-> pf_irq);
endmodule

// File: tb/tb_pwr_fail_ctl.sv
`timescale 1ns/1ps
module tb_pwr_fail_ctl;
    localparam int TW = 16;
    localparam int FC = 4;

    logic          clk = 1'b0;
    logic          rst_n, main_ok, batt_present, batt_low, bus_wr_in, clr_wr;
    logic [3:0]    clr_mask;
    logic [TW-1:0] time_now;
    logic          bus_wr_out, pf_irq, bus_lock, on_batt;
    logic [TW-1:0] save_time;
    logic [3:0]    status;
    int            total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pwr_fail_ctl #(.TIME_W(TW), .FILT_CYC(FC)) dut (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .batt_present(batt_present),
        .batt_low(batt_low), .time_now(time_now), .bus_wr_in(bus_wr_in),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .bus_wr_out(bus_wr_out),
        .pf_irq(pf_irq), .bus_lock(bus_lock), .on_batt(on_batt),
        .save_time(save_time), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [TW-1:0] exp_save;
        rst_n = 1'b0; main_ok = 1'b1; batt_present = 1'b0; batt_low = 1'b0;
        bus_wr_in = 1'b0; clr_wr = 1'b0; clr_mask = '0; time_now = '0;
        @(negedge clk);
        step(); step();
        // R10: reset state
        chk("R10 status", status, 0);
        chk("R10 lock", {pf_irq, bus_lock, on_batt}, 0);
        chk("R10 save", save_time, 0);
        rst_n = 1'b1;
        step();
        exp_save = '0;

        // R1 R2 R3 R4 R5 R6: sweep of dip lengths around the threshold
        for (int len = 1; len <= 7; len++) begin
            logic [TW-1:0] base;
            base = TW'(len * 1000);
            for (int k = 0; k < len; k++) begin
                main_ok = 1'b0;
                time_now = base + TW'(k);
                step();
            end
            time_now = base + 16'd500;
            if (len < FC) begin
                chk("R1 short dip lock", {bus_lock, on_batt, pf_irq}, 0);
                chk("R1 short dip save", save_time, exp_save);
                main_ok = 1'b1;
                step();
            end else begin
                exp_save = base + TW'(FC - 1);
                chk("R2 irq", pf_irq, 1);
                chk("R5 lock and batt", {bus_lock, on_batt}, 2'b11);
                chk("R4 save", save_time, exp_save);
                bus_wr_in = 1'b1;
                #0.1;
                chk("R3 write blocked", bus_wr_out, 0);
                clr_wr = 1'b1; clr_mask = 4'hF;
                step();
                clr_wr = 1'b0; bus_wr_in = 1'b0;
                chk("R3 clear ignored", status[0], 1);
                chk("R4 save held", save_time, exp_save);
                main_ok = 1'b1;
                for (int k = 0; k < FC - 1; k++) step();
                chk("R6 still locked", {bus_lock, on_batt}, 2'b11);
                step();
                chk("R6 released", {bus_lock, on_batt}, 0);
                chk("R6 sys power", status[2], 1);
                chk("R4 save after recovery", save_time, exp_save);
                bus_wr_in = 1'b1;
                #0.1;
                chk("R3 write passes", bus_wr_out, 1);
                bus_wr_in = 1'b0;
                clr_wr = 1'b1; clr_mask = 4'hF;
                step();
                clr_wr = 1'b0;
                chk("R9 clear all", status, 0);
            end
        end

        // R7: battery first applied
        batt_present = 1'b1;
        step();
        chk("R7 batt init", status, 4'b0010);
        step();
        // R8: low battery sticky
        batt_low = 1'b1;
        step();
        batt_low = 1'b0;
        step();
        chk("R8 low batt sticky", status, 4'b1010);
        // R9: selective clear
        clr_wr = 1'b1; clr_mask = 4'b0010;
        step();
        chk("R9 selective clear", status, 4'b1000);
        // R9: set wins over clear
        batt_low = 1'b1; clr_mask = 4'b1000;
        step();
        clr_wr = 1'b0; batt_low = 1'b0;
        chk("R9 set wins", status, 4'b1000);
        // R9: a bit not in the mask stays set
        clr_wr = 1'b1; clr_mask = 4'b0001;
        step();
        clr_wr = 1'b0;
        chk("R9 unmasked kept", status, 4'b1000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule